// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one load request from a group of 32 lanes that run together and turns it into the smallest set of memory transactions. Each active lane supplies a byte address of a 4-byte word. The block groups the addresses by the aligned 128-byte line they fall in. It then issues one transaction for each distinct line, lowest line first, over a valid/ready channel.

Alongside the transactions the block reports two byte counts. The first is the bytes the lanes asked for: 4 per active lane. The second is the bytes memory must move: 128 per issued line. Dividing the first by the second gives the coalescing efficiency. Consecutive words from a full group fit in one line, so they give 128 of 128 bytes. Lanes one line or more apart give 32 lines, so 128 of 4096 bytes.

A request is accepted only while the block is idle. The block pulses `done` when its last transaction has been taken, or one cycle after it accepts a request with no active lane.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `txn_valid` and `done` are 0, and both byte counts are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the request completes. Request inputs presented while `req_ready` is 0 have no effect.
- R3: The line of a lane is its byte address divided by 128 (address bits [6:0] are dropped). `txn_line` carries that line index. Every distinct line of the active lanes is issued exactly once.
- R4: The lines of one request are issued in strictly ascending order.
- R5: A lane whose `req_mask` bit is 0 contributes no line and no requested bytes, whatever its address.
- R6: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid` and `txn_line` hold their values. One line is consumed per edge with both high.
- R7: `txn_last` is 1 exactly on the final transaction of a request.
- R8: `req_bytes` equals 4 times the number of set bits in the accepted `req_mask`, from the cycle after acceptance.
- R9: `xfer_bytes` is cleared on acceptance and grows by 128 on each consumed transaction. At `done` it equals 128 times the number of distinct lines.
- R10: An accepted request with an all-zero mask issues no transaction and raises `done` in the next cycle, with `req_ready` still 1.
- R11: `done` is a one-cycle pulse in the cycle after the last transaction is consumed. `req_ready` is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can accept a request |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| req_addr | input | 1024 | Lane byte addresses, lane i in bits [32i+31:32i] |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | 25 | Line index (byte address / 128) |
| txn_last | output | 1 | Final transaction of the request |
| done | output | 1 | One-cycle completion pulse |
| req_bytes | output | 13 | Bytes requested by active lanes |
| xfer_bytes | output | 13 | Bytes transferred so far (lines × 128) |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit addresses, 128-byte lines and 4-byte words. These values make both stated extremes reachable. Consecutive words give a single line, and a 128-byte stride gives 32 lines and 4096 transferred bytes, which is the largest count the 13-bit counters must hold. A 64-byte stride gives 16 lines with two lanes per line, which exercises merging of duplicate lines. Descending strides, random scattered addresses with random masks, and a stalling `txn_ready` check the ascending order and the hold behaviour while the consumer is not ready.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int CNT_W  = $clog2(LANES * LINE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_mask,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [LINE_W-1:0]       txn_line,
  output logic                    txn_last,
  output logic                    done,
  output logic [CNT_W-1:0]        req_bytes,
  output logic [CNT_W-1:0]        xfer_bytes
);

  logic              busy;
  logic [LANES-1:0]  pend, match, rest;
  logic [LINE_W-1:0] lines [LANES];
  logic [LINE_W-1:0] min_line;
  logic [CNT_W-1:0]  act_cnt;

  wire accept = req_valid && req_ready;
  wire fire   = txn_valid && txn_ready;

  always_comb begin
    min_line = '1;
    for (int l = 0; l < LANES; l++)
      if (pend[l] && lines[l] < min_line) min_line = lines[l];
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign match[g] = pend[g] && (lines[g] == min_line);
    end
  endgenerate

  always_comb begin
    act_cnt = '0;
    for (int l = 0; l < LANES; l++) act_cnt = act_cnt + CNT_W'(req_mask[l]);
  end

  assign rest      = pend & ~match;
  assign req_ready = !busy;
  assign txn_valid = busy;
  assign txn_line  = min_line;
  assign txn_last  = busy && (rest == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      pend       <= '0;
      req_bytes  <= '0;
      xfer_bytes <= '0;
      for (int l = 0; l < LANES; l++) lines[l] <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        for (int l = 0; l < LANES; l++)
          lines[l] <= req_addr[l*ADDR_W+OFF_W +: LINE_W];
        pend       <= req_mask;
        busy       <= |req_mask;
        done       <= ~|req_mask;
        req_bytes  <= act_cnt * CNT_W'(WORD_BYTES);
        xfer_bytes <= '0;
      end else if (fire) begin
        pend       <= rest;
        xfer_bytes <= xfer_bytes + CNT_W'(LINE_BYTES);
        if (rest == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_line)); // R6
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !txn_last |=> txn_valid && (txn_line > $past(txn_line))); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fire && txn_last |=> done && req_ready); // R11
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_mask == '0) |=> done && !txn_valid && (xfer_bytes == '0)); // R10
  AST_REQ_LE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_bytes <= xfer_bytes || (xfer_bytes == '0 && req_bytes == '0)); // R9
  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid); // R11
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !(txn_ready && txn_last) |=> !req_ready); // R2

endmodule

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
  localparam int LANES = 32, AW = 32, LW = 25, CW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES-1:0] req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic txn_valid, txn_last, done;
  logic txn_ready = 1'b1;
  logic [LW-1:0] txn_line;
  logic [CW-1:0] req_bytes, xfer_bytes;

  always #2 clk = ~clk;

  warp_coalescer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_line(txn_line), .txn_last(txn_last),
    .done(done), .req_bytes(req_bytes), .xfer_bytes(xfer_bytes)
  );

  int errors = 0, checks = 0;
  int ready_mode = 0;

  // behavioural reference
  int unsigned q[$];
  bit m_busy = 0, m_done = 0;
  int m_req = 0, m_xfer = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit nd;
    nd = 0;
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_req = 0; m_xfer = 0;
    end else if (m_busy) begin
      if (txn_ready) begin
        void'(q.pop_front());
        m_xfer += 128;
        if (q.size() == 0) begin m_busy = 0; nd = 1; end
      end
    end else if (req_valid) begin
      q.delete(); m_req = 0; m_xfer = 0;
      for (int l = 0; l < LANES; l++) begin
        if (req_mask[l]) begin
          int unsigned ln;
          int pos;
          bit dup;
          ln = req_addr[l*AW +: AW] >> 7;
          m_req += 4;
          pos = q.size(); dup = 0;
          for (int k = q.size() - 1; k >= 0; k--) begin
            if (q[k] == ln) dup = 1;
            if (q[k] > ln) pos = k;
          end
          if (!dup) q.insert(pos, ln);
        end
      end
      m_busy = (q.size() != 0);
      nd = (q.size() == 0);
    end
    m_done = nd;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 req_ready", req_ready, !m_busy);
      chk("R3 txn_valid", txn_valid, m_busy);
      if (m_busy) begin
        chk("R3 R4 R5 R6 txn_line", txn_line, q[0]);
        chk("R7 txn_last", txn_last, q.size() == 1);
      end
      chk("R11 done", done, m_done);
      chk("R9 xfer_bytes", xfer_bytes, m_xfer);
      if (m_busy || m_done) chk("R8 req_bytes", req_bytes, m_req);
      if (m_done && m_req == 0) chk("R10 empty xfer", xfer_bytes, 0);
    end
    case (ready_mode)
      0: txn_ready = 1'b1;
      1: txn_ready = ($urandom % 3) != 0;
      default: txn_ready = ($urandom % 5) == 0;
    endcase
  end

  task automatic wait_idle(bit junk);
    @(negedge clk);
    while (!req_ready) begin
      if (junk) begin
        req_valid = 1'b1; req_mask = $urandom;
        for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = $urandom;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic send_stride(logic [31:0] mask, int unsigned base, int stride, bit junk);
    wait_idle(0);
    req_mask = mask;
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = base + l * stride;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle(junk);
  endtask

  task automatic send_rand(logic [31:0] mask, int unsigned span);
    wait_idle(0);
    req_mask = mask;
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = 32'h4000_0000 + ($urandom % span);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle(0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 txn_valid", txn_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 req_bytes", req_bytes, 0);
    chk("R1 xfer_bytes", xfer_bytes, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      send_stride('1, 32'h1000, 4, 0);          // one line
      send_stride('1, 32'h1000, 64, 0);         // 16 lines, pairs merge
      send_stride('1, 32'h2000, 128, 1);        // 32 lines, junk while busy (R2)
      send_stride('1, 32'h0000_0070, 4, 0);     // straddles two lines
      send_stride('1, 32'h9000, -132, 0);       // descending addresses (R4)
      send_stride(32'h0000_0000, 32'h5000, 4, 0); // empty mask (R10)
      send_stride(32'h8000_0001, 32'h3000, 256, 0); // sparse mask (R5)
      send_stride(32'h5555_5555, 32'h6002, 131, 0); // unaligned offsets (R3)
      for (int i = 0; i < 40; i++) send_rand($urandom, 1 << (6 + i % 8));
    end
    ready_mode = 0;
    wait_idle(0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule